// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Transmitter

This block turns one parallel character into an asynchronous serial frame on a single output wire. A character is handed over on a valid/ready handshake together with three small configuration fields: character length, parity mode and stop length. The frame is clocked out on a one-cycle timing strobe from an external divider. That strobe runs at twice the bit rate, so one bit time is two strobes. Timing the stop period in half bits is what makes a stop length of one and a half bits possible.

The line rests high. A frame is a low start bit, then the data bits with the least significant bit first, then an optional parity bit, then a high stop period. The configuration is captured when the handshake completes, so a frame already on the wire is never altered. A character offered while a frame is still in flight, including during its stop period, waits. It is taken only once the stop period has fully elapsed.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, and between frames, `tx_line` is 1, `busy` is 0 and `in_ready` is 1.
- R2: A frame begins with a start level of 0 that lasts exactly 2 `baud_tick` pulses, counted from the first pulse after the accepting clock edge.
- R3: Data bits go out least significant bit first, each for 2 `baud_tick` pulses. The count is set by `cfg_width`: 2'b00 gives 5 bits, 2'b01 gives 7 bits, and 2'b10 or 2'b11 gives 8 bits. The line changes only on clock edges where `baud_tick` is 1.
- R4: With `cfg_parity` 2'b01 (odd), a parity bit is sent after the last data bit, for 2 pulses, making the count of ones in the sent data plus parity odd. With 2'b10 (even), the parity bit makes that count even.
- R5: With `cfg_parity` 2'b00 or 2'b11, no parity slot is sent, and the stop period follows the last data bit directly.
- R6: The stop period holds the line at 1 for a number of `baud_tick` pulses set by `cfg_stop`: 2'b00 gives 2 pulses (1 bit), 2'b01 gives 3 (1.5 bits), and 2'b10 or 2'b11 gives 4 (2 bits). `busy` falls on the clock edge of its last pulse.
- R7: `in_ready` equals the inverse of `busy`. A character is accepted on a clock edge with `in_valid` and `in_ready` both 1, and `busy` is 1 from the next cycle.
- R8: Changes on `cfg_width`, `cfg_parity`, `cfg_stop` or `in_data` after acceptance have no effect on the frame in flight.
- R9: A character held on `in_valid` during a frame is not accepted before that frame's stop period has fully elapsed. It is accepted on the first clock edge after `busy` falls.
- R10: Bits of `in_data` above the selected width are ignored. They are neither sent nor counted in parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| baud_tick | input | 1 | One-cycle strobe at twice the bit rate |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Character can be taken this cycle |
| in_data | input | 8 | Character to send |
| cfg_width | input | 2 | Character length select |
| cfg_parity | input | 2 | Parity mode select |
| cfg_stop | input | 2 | Stop length select |
| tx_line | output | 1 | Serial output line |
| busy | output | 1 | Frame in progress |

## Verification
The hardest situation to reach from the ports is a character offered in the middle of a stop period, especially the odd three-pulse stop. The waiting character must be held off for exactly the remaining pulses and then start on the next edge. The bench watches its own record of the half-bit slots of the running frame. When that record shows the frame has entered its stop period, the bench raises `in_valid` with a second character. It then checks that `in_ready` stays low until the last stop pulse and that the first frame's record holds the full stop length. The second frame must then follow intact. Changing the configuration right after acceptance covers the latching rule.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int DATA_MAX      = 8;
    localparam int TICKS_PER_BIT = 2;
    localparam int CNT_W         = 3;
    localparam int NB_W          = $clog2(DATA_MAX + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    typedef struct packed {
        logic [NB_W-1:0]  nbits;
        logic             par_en;
        logic             par_odd;
        logic [CNT_W-1:0] stop_ticks;
    } frame_cfg_t;

    function automatic logic [NB_W-1:0] width_bits(input logic [1:0] sel);
        case (sel)
            2'b00:   return NB_W'(5);
            2'b01:   return NB_W'(7);
            default: return NB_W'(8);
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] stop_len(input logic [1:0] sel);
        case (sel)
            2'b00:   return CNT_W'(2);
            2'b01:   return CNT_W'(3);
            default: return CNT_W'(4);
        endcase
    endfunction

    function automatic logic [DATA_MAX-1:0] mask_data(input logic [DATA_MAX-1:0] d,
                                                      input logic [NB_W-1:0] n);
        logic [DATA_MAX-1:0] m;
        for (int i = 0; i < DATA_MAX; i++) begin
            m[i] = d[i] & (i < int'(n));
        end
        return m;
    endfunction

    function automatic logic parity_bit(input logic [DATA_MAX-1:0] d, input logic odd);
        return odd ? ~(^d) : (^d);
    endfunction

endpackage

// File: rtl/tx_cfg_decode.sv
module tx_cfg_decode
    import uart_tx_pkg::*;
(
    input  logic [1:0] sel_width,
    input  logic [1:0] sel_parity,
    input  logic [1:0] sel_stop,
    output frame_cfg_t cfg
);
    always_comb begin
        cfg.nbits      = width_bits(sel_width);
        cfg.par_en     = (sel_parity == 2'b01) || (sel_parity == 2'b10);
        cfg.par_odd    = (sel_parity == 2'b01);
        cfg.stop_ticks = stop_len(sel_stop);
    end
endmodule

// File: rtl/tx_tick_timer.sv
module tx_tick_timer #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          tick,
    input  logic [CW-1:0] len,
    output logic          done
);
    logic [CW-1:0] cnt;

    assign done = tick && (cnt == len - CW'(1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (done) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] din,
    output logic         lsb
);
    logic [W-1:0] q;

    assign lsb = q[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= din;
        end else if (shift) begin
            q <= q >> 1;
        end
    end
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import uart_tx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                baud_tick,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [DATA_MAX-1:0] in_data,
    input  logic [1:0]          cfg_width,
    input  logic [1:0]          cfg_parity,
    input  logic [1:0]          cfg_stop,
    output logic                tx_line,
    output logic                busy
);
    tx_state_e           state;
    frame_cfg_t          cfg_dec;
    frame_cfg_t          cfg_q;
    logic [NB_W-1:0]     bit_idx;
    logic                par_q;
    logic                accept;
    logic                slot_done;
    logic [CNT_W-1:0]    slot_len;
    logic                data_lsb;
    logic [DATA_MAX-1:0] data_masked;

    assign busy     = (state != ST_IDLE);
    assign in_ready = !busy;
    assign accept   = in_valid && in_ready;
    assign slot_len = (state == ST_STOP) ? cfg_q.stop_ticks : CNT_W'(TICKS_PER_BIT);
    assign data_masked = mask_data(in_data, cfg_dec.nbits);

    tx_cfg_decode u_dec (
        .sel_width  (cfg_width),
        .sel_parity (cfg_parity),
        .sel_stop   (cfg_stop),
        .cfg        (cfg_dec)
    );

    tx_tick_timer #(.CW(CNT_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clear (accept),
        .tick  (baud_tick),
        .len   (slot_len),
        .done  (slot_done)
    );

    tx_shifter #(.W(DATA_MAX)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .load  (accept),
        .shift (slot_done && (state == ST_DATA)),
        .din   (data_masked),
        .lsb   (data_lsb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cfg_q   <= '0;
            bit_idx <= '0;
            par_q   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state   <= ST_START;
                        cfg_q   <= cfg_dec;
                        par_q   <= parity_bit(data_masked, cfg_dec.par_odd);
                        bit_idx <= '0;
                    end
                end
                ST_START: begin
                    if (slot_done) state <= ST_DATA;
                end
                ST_DATA: begin
                    if (slot_done) begin
                        if (bit_idx == cfg_q.nbits - NB_W'(1)) begin
                            state <= cfg_q.par_en ? ST_PARITY : ST_STOP;
                        end else begin
                            bit_idx <= bit_idx + NB_W'(1);
                        end
                    end
                end
                ST_PARITY: begin
                    if (slot_done) state <= ST_STOP;
                end
                ST_STOP: begin
                    if (slot_done) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        case (state)
            ST_START:  tx_line = 1'b0;
            ST_DATA:   tx_line = data_lsb;
            ST_PARITY: tx_line = par_q;
            default:   tx_line = 1'b1;
        endcase
    end

endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk
    import uart_tx_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       baud_tick,
    input logic       in_valid,
    input logic       in_ready,
    input logic       tx_line,
    input logic       busy,
    input frame_cfg_t cfg_q
);
    assert_start_low_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !tx_line);

    assert_accept_busy_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> busy);

    assert_hold_between_ticks_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && !baud_tick) |=> $stable(tx_line));

    assert_stop_high_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(tx_line) && $past(baud_tick)));

    assert_cfg_held_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cfg_q));
endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .baud_tick (baud_tick),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .tx_line   (tx_line),
    .busy      (busy),
    .cfg_q     (cfg_q)
);

// File: tb/tb_uart_frame_tx.sv
module tb_uart_frame_tx;
    localparam int TDIV = 5;
    localparam int MAXS = 32;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'h00;
    logic [1:0] cfg_width = 2'b10;
    logic [1:0] cfg_parity = 2'b00;
    logic [1:0] cfg_stop = 2'b00;
    logic       tx_line;
    logic       busy;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [MAXS-1:0] cap, prev_cap, exp_v;
    int cap_n = 0, prev_n = 0, exp_n = 0;

    uart_frame_tx dut (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data), .cfg_width(cfg_width),
        .cfg_parity(cfg_parity), .cfg_stop(cfg_stop), .tx_line(tx_line), .busy(busy)
    );

    always #4 clk = ~clk;

    initial begin
        forever begin
            repeat (TDIV - 1) @(posedge clk);
            #1 baud_tick = 1'b1;
            @(posedge clk);
            #1 baud_tick = 1'b0;
        end
    end

    always @(negedge clk) begin
        if (busy && baud_tick && cap_n < MAXS) begin
            cap[cap_n] = tx_line;
            cap_n++;
        end
        if (in_valid && in_ready) begin
            prev_cap = cap;
            prev_n   = cap_n;
            cap      = '0;
            cap_n    = 0;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic make_expected(input logic [7:0] d, input logic [1:0] w,
                                 input logic [1:0] p, input logic [1:0] s);
        int n, ones, st;
        logic pb;
        n = (w == 2'b00) ? 5 : (w == 2'b01) ? 7 : 8;
        st = (s == 2'b00) ? 2 : (s == 2'b01) ? 3 : 4;
        exp_v = '0;
        exp_n = 0;
        ones = 0;
        exp_v[exp_n++] = 1'b0;
        exp_v[exp_n++] = 1'b0;
        for (int i = 0; i < n; i++) begin
            exp_v[exp_n++] = d[i];
            exp_v[exp_n++] = d[i];
            ones += int'(d[i]);
        end
        if (p == 2'b01 || p == 2'b10) begin
            pb = (p == 2'b01) ? ~ones[0] : ones[0];
            exp_v[exp_n++] = pb;
            exp_v[exp_n++] = pb;
        end
        for (int i = 0; i < st; i++) exp_v[exp_n++] = 1'b1;
    endtask

    task automatic compare(input logic [MAXS-1:0] got, input int got_n, input string req);
        check(got_n == exp_n, req, "slot count", 64'(got_n), 64'(exp_n));
        check(got == exp_v, req, "slot levels", 64'(got), 64'(exp_v));
    endtask

    task automatic offer(input logic [7:0] d, input logic [1:0] w,
                         input logic [1:0] p, input logic [1:0] s);
        @(posedge clk); #1;
        in_data = d; cfg_width = w; cfg_parity = p; cfg_stop = s; in_valid = 1'b1;
        do @(negedge clk); while (!in_ready);
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy);
        #1;
    endtask

    task automatic t_frame(input logic [7:0] d, input logic [1:0] w,
                           input logic [1:0] p, input logic [1:0] s, input string req);
        offer(d, w, p, s);
        make_expected(d, w, p, s);
        wait_idle();
        compare(cap, cap_n, req);
        check(tx_line === 1'b1 && in_ready === 1'b1, "R1", "idle after frame",
              64'({tx_line, in_ready}), 64'(2'b11));
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(tx_line === 1'b1 && busy === 1'b0 && in_ready === 1'b1, "R1",
              "reset state", 64'({tx_line, busy, in_ready}), 64'(3'b101));
    endtask

    task automatic t_handshake();
        offer(8'h5A, 2'b10, 2'b00, 2'b00);
        @(negedge clk);
        check(busy === 1'b1 && in_ready === 1'b0, "R7", "busy after accept",
              64'({busy, in_ready}), 64'(2'b10));
        make_expected(8'h5A, 2'b10, 2'b00, 2'b00);
        wait_idle();
        compare(cap, cap_n, "R7");
    endtask

    task automatic t_cfg_latch();
        offer(8'h96, 2'b01, 2'b01, 2'b01);
        @(posedge clk); #1;
        in_data = 8'h00; cfg_width = 2'b00; cfg_parity = 2'b10; cfg_stop = 2'b10;
        make_expected(8'h96, 2'b01, 2'b01, 2'b01);
        wait_idle();
        compare(cap, cap_n, "R8");
    endtask

    task automatic t_wait_stop();
        bit early;
        early = 1'b0;
        offer(8'hC3, 2'b10, 2'b10, 2'b01);
        make_expected(8'hC3, 2'b10, 2'b10, 2'b01);
        do @(negedge clk); while (cap_n < exp_n - 2);
        @(posedge clk); #1;
        in_data = 8'h2D; cfg_width = 2'b00; cfg_parity = 2'b01; cfg_stop = 2'b00;
        in_valid = 1'b1;
        do begin
            @(negedge clk);
            if (busy && in_ready) early = 1'b1;
        end while (busy);
        #1;
        check(!early, "R9", "ready during stop", 64'(early), 64'(0));
        compare(prev_cap, prev_n, "R9");
        @(posedge clk); #1;
        in_valid = 1'b0;
        @(negedge clk);
        check(busy === 1'b1, "R9", "second frame started", 64'(busy), 64'(1));
        make_expected(8'h2D, 2'b00, 2'b01, 2'b00);
        wait_idle();
        compare(cap, cap_n, "R9");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_frame(8'hA5, 2'b10, 2'b00, 2'b00, "R3 R5 R6");
        t_frame(8'h3C, 2'b01, 2'b01, 2'b01, "R2 R4 R6");
        t_frame(8'hF3, 2'b00, 2'b10, 2'b10, "R10 R4");
        t_frame(8'h13, 2'b00, 2'b10, 2'b10, "R10");
        t_frame(8'h81, 2'b11, 2'b11, 2'b11, "R5 R3");
        t_frame(8'h6E, 2'b10, 2'b10, 2'b00, "R4");
        t_handshake();
        t_cfg_latch();
        t_wait_stop();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule